// File: doc/BRIEF.md
# Paged MDIO-to-32-bit register bridge

This block lets a management slave that only understands 16-bit MDIO transfers reach a space of 32-bit internal registers addressed by byte address. Frames arrive already decoded from the serial line: a PHY address, a register number, a read/write flag and 16 bits of write data, qualified by a one-cycle valid. A page register, loaded through one fixed PHY address, supplies the upper address bits. A group of eight consecutive PHY addresses then reaches the registers of the current page, with each 32-bit register split into a low half at an even register number and a high half at the following odd one.

Writes are collected: the low half is held in a buffer and a single 32-bit write strobe is produced when the high half arrives. Reads fetch the whole 32-bit word when the low half is requested and hand back the saved upper half when the high half is requested. A host therefore always transfers low half first, then high half, and rewrites the page only when it moves to another page.

Top module: `mdio_paged_bridge`

## Requirements
- R1: After reset the page register holds 0 and no response is pending (`rsp_valid` low).
- R2: A write frame to PHY address 0x18, register 0, loads the page with write data bits 9:0; a write to PHY 0x18 at any other register number leaves the page unchanged.
- R3: The page keeps its value across any number of data accesses until the next page write.
- R4: A frame to PHY addresses 0x10 to 0x17 drives `bus_addr` = {page[9:0], PHY address bits 2:0, register number bits 4:1, 2'b00} in the same cycle (19 bits).
- R5: A write to an even register number stores its data in a low-half buffer and raises no strobe; a write to an odd register number raises `bus_we` for exactly that cycle with `bus_wdata` = {frame data, buffered low half}. The buffer is 0 after reset. `bus_we` and `bus_rd` are never high together.
- R6: A read of an even register number raises `bus_rd` in that cycle; the next cycle returns `bus_rdata[15:0]` and the bridge saves `bus_rdata[31:16]`.
- R7: A read of an odd register number raises no `bus_rd` and returns the upper half saved by the latest even-register read (0 after reset).
- R8: Every read frame gets `rsp_valid` high for exactly the following cycle and no other frame does; a read of PHY 0x18 register 0 returns the page zero-extended, and a read of any unmapped address returns 0.
- R9: Frames to PHY addresses outside 0x10 to 0x18 raise no bus strobe and change neither the page nor either half buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle qualifier for a decoded frame |
| frm_phy | input | 5 | PHY address of the frame |
| frm_reg | input | 5 | Register number of the frame |
| frm_write | input | 1 | 1 = write frame, 0 = read frame |
| frm_wdata | input | 16 | Write data of the frame |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read frame |
| rsp_data | output | 16 | Read response data |
| bus_addr | output | 19 | Byte address of the internal register |
| bus_we | output | 1 | 32-bit write strobe |
| bus_wdata | output | 32 | 32-bit write data |
| bus_rd | output | 1 | 32-bit read strobe |
| bus_rdata | input | 32 | Read data, valid in the cycle of `bus_rd` |

## Verification
On every cycle the assertions check that the page changes only on a page write and then takes the written value, that the two strobes never coincide and stay low without a frame, that each read frame and only a read frame produces a response in the next cycle, and that a high-half read returns the saved upper half. Whether the address bits land in the right fields, whether the combined write word pairs the right halves, what an unmapped read returns and that stray PHY addresses leave all state untouched can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int PAGE_W  = 10;
    localparam int SUB_W   = 3;
    localparam int ADDR_W  = PAGE_W + SUB_W + (REG_W - 1) + 2;

    localparam logic [PHY_W-1:0] PAGE_PHY_ADDR = 5'h18;
    localparam logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10;
    localparam logic [REG_W-1:0] PAGE_REG_NUM  = '0;

    typedef struct packed {
        logic              valid;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regn;
        logic              wr;
        logic [HALF_W-1:0] data;
    } frame_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PAGE_WR,
        OP_PAGE_RD,
        OP_LO_WR,
        OP_HI_WR,
        OP_LO_RD,
        OP_HI_RD,
        OP_NULL_RD
    } op_e;

    function automatic logic op_is_read(op_e op);
        return (op == OP_PAGE_RD) || (op == OP_LO_RD) ||
               (op == OP_HI_RD)   || (op == OP_NULL_RD);
    endfunction

    function automatic logic [ADDR_W-1:0] join_addr(
        logic [PAGE_W-1:0] page,
        logic [SUB_W-1:0]  sub,
        logic [REG_W-1:0]  regn
    );
        return {page, sub, regn[REG_W-1:1], 2'b00};
    endfunction

endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
    import mpb_pkg::*;
(
    input  frame_t frm,
    output op_e    op
);
    logic hit_page;
    logic hit_data;

    assign hit_page = (frm.phy == PAGE_PHY_ADDR) && (frm.regn == PAGE_REG_NUM);
    assign hit_data = (frm.phy[PHY_W-1:SUB_W] == DATA_PHY_BASE[PHY_W-1:SUB_W]);

    always_comb begin
        op = OP_NONE;
        if (frm.valid) begin
            if (hit_data) begin
                unique case ({frm.wr, frm.regn[0]})
                    2'b10:   op = OP_LO_WR;
                    2'b11:   op = OP_HI_WR;
                    2'b00:   op = OP_LO_RD;
                    default: op = OP_HI_RD;
                endcase
            end else if (hit_page) begin
                op = frm.wr ? OP_PAGE_WR : OP_PAGE_RD;
            end else if (!frm.wr) begin
                op = OP_NULL_RD;
            end
        end
    end
endmodule

// File: rtl/mpb_page_reg.sv
module mpb_page_reg
    import mpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HALF_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (load)
            page <= din[PAGE_W-1:0];
    end

    AST_PAGE_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
        load |=> page == $past(din[PAGE_W-1:0])); // R2

    AST_PAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(page)); // R3
endmodule

// File: rtl/mpb_halves.sv
module mpb_halves
    import mpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [HALF_W-1:0] wdata,
    input  logic [WORD_W-1:0] rdata,
    input  logic [PAGE_W-1:0] page,
    output logic [HALF_W-1:0] lo_buf,
    output logic              rsp_valid,
    output logic [HALF_W-1:0] rsp_data
);
    logic [HALF_W-1:0] hi_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_buf    <= '0;
            hi_buf    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (op == OP_LO_WR)
                lo_buf <= wdata;
            if (op == OP_LO_RD)
                hi_buf <= rdata[WORD_W-1:HALF_W];
            rsp_valid <= op_is_read(op);
            unique case (op)
                OP_LO_RD:   rsp_data <= rdata[HALF_W-1:0];
                OP_HI_RD:   rsp_data <= hi_buf;
                OP_PAGE_RD: rsp_data <= HALF_W'(page);
                default:    rsp_data <= '0;
            endcase
        end
    end

    AST_HI_FROM_SAVED: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HI_RD) |=> rsp_data == $past(hi_buf)); // R7

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        op_is_read(op) |=> rsp_valid); // R8

    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !op_is_read(op) |=> !rsp_valid); // R8
endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
    import mpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [4:0]        frm_phy,
    input  logic [4:0]        frm_reg,
    input  logic              frm_write,
    input  logic [15:0]       frm_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_data,
    output logic [18:0]       bus_addr,
    output logic              bus_we,
    output logic [31:0]       bus_wdata,
    output logic              bus_rd,
    input  logic [31:0]       bus_rdata
);
    frame_t            frm;
    op_e               op;
    logic [PAGE_W-1:0] page;
    logic [HALF_W-1:0] lo_buf;

    assign frm = '{valid: frm_valid, phy: frm_phy, regn: frm_reg,
                   wr: frm_write, data: frm_wdata};

    mpb_decode u_decode (
        .frm (frm),
        .op  (op)
    );

    mpb_page_reg u_page (
        .clk  (clk),
        .rst  (rst),
        .load (op == OP_PAGE_WR),
        .din  (frm_wdata),
        .page (page)
    );

    mpb_halves u_halves (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (frm_wdata),
        .rdata     (bus_rdata),
        .page      (page),
        .lo_buf    (lo_buf),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign bus_addr  = join_addr(page, frm_phy[SUB_W-1:0], frm_reg);
    assign bus_we    = (op == OP_HI_WR);
    assign bus_rd    = (op == OP_LO_RD);
    assign bus_wdata = {frm_wdata, lo_buf};

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_rd)); // R5

    AST_QUIET_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |-> !bus_we && !bus_rd); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid); // R1
endmodule

// File: tb/mdio_paged_bridge_tb.sv
`timescale 1ns/1ps
module mdio_paged_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [4:0]  frm_phy = '0;
    logic [4:0]  frm_reg = '0;
    logic        frm_write = 1'b0;
    logic [15:0] frm_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [18:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(logic [18:0] a);
        return {~a[15:0], a[18:3]};
    endfunction

    assign bus_rdata = mem_word(bus_addr);

    mdio_paged_bridge dut_i (
        .clk(clk), .rst(rst),
        .frm_valid(frm_valid), .frm_phy(frm_phy), .frm_reg(frm_reg),
        .frm_write(frm_write), .frm_wdata(frm_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural model state
    logic [9:0]  m_page = '0;
    logic [15:0] m_lo   = '0;
    logic [15:0] m_hi   = '0;
    logic        e_rv   = 1'b0;
    logic [15:0] e_rd   = '0;
    string       e_tag  = "R1";

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cycle(logic v, logic [4:0] phy, logic [4:0] rg,
                         logic wr, logic [15:0] d);
        logic is_data, is_page, x_we, x_rd;
        logic [18:0] x_addr;
        @(negedge clk);
        check({e_tag, " rsp_valid R8"}, 32'(rsp_valid), 32'(e_rv));
        if (e_rv) check(e_tag, 32'(rsp_data), 32'(e_rd));
        frm_valid = v; frm_phy = phy; frm_reg = rg; frm_write = wr; frm_wdata = d;
        #1;
        is_data = v && (phy[4:3] == 2'b10);
        is_page = v && (phy == 5'h18) && (rg == 5'd0);
        x_addr  = {m_page, phy[2:0], rg[4:1], 2'b00};
        x_we    = is_data && wr && rg[0];
        x_rd    = is_data && !wr && !rg[0];
        check("R5 bus_we", 32'(bus_we), 32'(x_we));
        check("R6 bus_rd", 32'(bus_rd), 32'(x_rd));
        if (is_data) check("R4 bus_addr", 32'(bus_addr), 32'(x_addr));
        if (x_we) check("R5 bus_wdata", bus_wdata, {d, m_lo});
        // expected response for next cycle
        e_rv = v && !wr;
        e_rd = '0;
        e_tag = "R8";
        if (e_rv) begin
            if (is_page) begin e_rd = 16'(m_page); e_tag = "R2/R3 page"; end
            else if (x_rd) begin e_rd = mem_word(x_addr)[15:0]; e_tag = "R6"; end
            else if (is_data) begin e_rd = m_hi; e_tag = "R7"; end
        end
        if (is_page && wr) m_page = d[9:0];
        if (is_data && wr && !rg[0]) m_lo = d;
        if (x_rd) m_hi = mem_word(x_addr)[31:16];
    endtask

    task automatic idle();
        cycle(1'b0, 5'h0, 5'h0, 1'b0, 16'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, first access addresses page 0
        e_tag = "R1";
        idle();
        cycle(1, 5'h18, 5'd0, 0, 16'h0);          // page read -> 0 (R1)
        cycle(1, 5'h13, 5'd6, 0, 16'h0);          // low read page 0 (R4, R6)
        cycle(1, 5'h13, 5'd7, 0, 16'h0);          // high read (R7)
        cycle(1, 5'h11, 5'd3, 0, 16'h0);          // high read, no fresh low (R7)
        // R5: write with low buffer still 0, then pair
        cycle(1, 5'h12, 5'd9, 1, 16'hBEEF);
        cycle(1, 5'h12, 5'd8, 1, 16'h1234);
        idle();
        cycle(1, 5'h12, 5'd9, 1, 16'hABCD);
        // R2: page write, then wrong register at page PHY ignored
        cycle(1, 5'h18, 5'd0, 1, 16'hF2A5);
        cycle(1, 5'h18, 5'd1, 1, 16'h0011);
        cycle(1, 5'h18, 5'd0, 0, 16'h0);
        // R3: many accesses on the page
        for (int i = 0; i < 8; i++) begin
            cycle(1, 5'(8'h10 + i), 5'(2 * i), 0, 16'h0);
            cycle(1, 5'(8'h10 + i), 5'(2 * i + 1), 0, 16'h0);
        end
        // R9: stray PHY addresses
        cycle(1, 5'h05, 5'd0, 1, 16'h7777);
        cycle(1, 5'h1F, 5'd2, 1, 16'h5555);
        cycle(1, 5'h09, 5'd4, 0, 16'h0);
        cycle(1, 5'h17, 5'd31, 1, 16'h9999);      // uses unchanged low buffer
        // boundary: page all ones, sub 7, register 30/31
        cycle(1, 5'h18, 5'd0, 1, 16'hFFFF);
        cycle(1, 5'h17, 5'd30, 1, 16'hCAFE);
        cycle(1, 5'h17, 5'd31, 1, 16'hF00D);
        cycle(1, 5'h17, 5'd30, 0, 16'h0);
        cycle(1, 5'h17, 5'd31, 0, 16'h0);
        cycle(1, 5'h18, 5'd0, 0, 16'h0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [4:0] p;
            sel = $urandom_range(0, 9);
            if (sel == 0) p = 5'h18;
            else if (sel == 1) p = 5'($urandom_range(0, 15));
            else p = 5'(8'h10 + $urandom_range(0, 7));
            cycle($urandom_range(0, 4) != 0, p,
                  (sel == 0 && $urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom_range(0, 31)),
                  1'($urandom_range(0, 1)), 16'($urandom));
        end
        idle();
        idle();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule